// File: doc/BRIEF.md
# 32-bit Multi-Function Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit. It takes two 32-bit operands and a 4-bit operation code. It returns a 32-bit result together with a zero flag, a signed-overflow flag and an unsigned carry-out. The datapath is a row of identical 1-bit slices. Each slice can optionally complement its A bit and its B bit. It then forms the AND, the OR and the full-adder sum of the two bits, and a 4-way select picks the slice's output from these three values and a "less" input.

The operation code packs an A-complement bit (bit 3), a B-negate bit (bit 2) and the 2-bit slice select (bits 1:0). Because of this layout, the same slices perform subtraction and NOR. The B-negate bit also becomes the carry into bit 0. For set-on-less-than, the unit subtracts B from A and forms the true signed sign of the difference. That sign is fed into the less input of slice 0, and every other slice receives 0. The zero flag reports an all-zero result, so a subtraction works as an equality test.

Top module: `alu32`

## Requirements
- R1: Code 4'b0000 returns opA AND opB.
- R2: Code 4'b0001 returns opA OR opB.
- R3: Code 4'b0010 returns the low 32 bits of opA + opB, and carryOut is the carry out of bit 31.
- R4: Code 4'b0110 returns opA - opB, formed as opA + ~opB + 1. carryOut is the carry out of bit 31, which is 1 when no borrow occurs.
- R5: Code 4'b0111 returns 32'd1 when opA < opB as signed two's-complement values and 32'd0 otherwise. This holds even when the internal subtraction overflows, for example 0x80000000 against 0x7FFFFFFF.
- R6: Code 4'b1100 returns NOR(opA, opB), formed as ~opA AND ~opB.
- R7: For every listed code, zeroFlag is 1 exactly when all 32 result bits are 0.
- R8: overflowFlag is 1 for add or subtract exactly when the signed result does not fit in 32 bits. This is the XOR of the carries into and out of bit 31.
- R9: For codes 0000, 0001, 0111 and 1100, both overflowFlag and carryOut are 0.
- R10: Any code other than the six listed returns a result of 0 with zeroFlag, overflowFlag and carryOut all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| ctrlWord | input | 4 | Operation code {A-complement, B-negate, select[1:0]} |
| result | output | 32 | Operation result |
| zeroFlag | output | 1 | Result is all zeros (listed codes only) |
| overflowFlag | output | 1 | Signed overflow on add or subtract |
| carryOut | output | 1 | Carry out of bit 31 on add or subtract |

## Verification
The hardest corners are the signed extremes. Comparing 0x80000000 with 0x7FFFFFFF makes the subtraction overflow, so a design that routed the raw sign bit back to bit 0 would report the wrong ordering. Adding 0x7FFFFFFF and 1, or subtracting 1 from 0x80000000, must raise overflow. A design that took overflow from the carry-out alone would miss these cases, or would flag unsigned wraps such as 0xFFFFFFFF + 1 instead. Subtracting equal operands must give zero with carry-out 1, which exposes a carry-in of bit 0 that is not tied to the negate control. The bench also sweeps all unlisted codes to catch stray results or stray flags that leak from the shared slices.

// File: rtl/alu32_pkg.sv
package alu32_pkg;

  // Selects which per-bit value a slice drives onto its result
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } sliceSel_e;

  // Strobes from the decoder to the slice row
  typedef struct packed {
    logic      aInvert;
    logic      bNegate;
    sliceSel_e sel;
    logic      arith;
    logic      valid;
  } strobes_t;

endpackage

// File: rtl/alu32_control.sv
module alu32_control
  import alu32_pkg::*;
(
  input  logic [3:0] ctrlWord,
  output strobes_t   strobes
);

  always_comb begin
    strobes = '0;
    case (ctrlWord)
      4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100: begin
        strobes.valid   = 1'b1;
        strobes.aInvert = ctrlWord[3];
        strobes.bNegate = ctrlWord[2];
        strobes.sel     = sliceSel_e'(ctrlWord[1:0]);
        strobes.arith   = (ctrlWord[1:0] == 2'b10);
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu32_slice.sv
module alu32_slice
  import alu32_pkg::*;
(
  input  logic      aBit,
  input  logic      bBit,
  input  logic      aInvert,
  input  logic      bNegate,
  input  logic      carryIn,
  input  logic      lessIn,
  input  sliceSel_e sel,
  output logic      resBit,
  output logic      gen,
  output logic      prop
);

  logic aEff;
  logic bEff;
  logic sumBit;

  always_comb begin
    aEff   = aBit ^ aInvert;
    bEff   = bBit ^ bNegate;
    gen    = aEff & bEff;
    prop   = aEff | bEff;
    sumBit = aEff ^ bEff ^ carryIn;
    case (sel)
      SEL_AND:  resBit = gen;
      SEL_OR:   resBit = prop;
      SEL_SUM:  resBit = sumBit;
      default:  resBit = lessIn;
    endcase
  end

endmodule

// File: rtl/alu32_datapath.sv
module alu32_datapath
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  strobes_t         strobes,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag,
  output logic             carryOut
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] genVec;
  logic [WIDTH-1:0] propVec;
  logic [WIDTH-1:0] sliceRes;
  logic [WIDTH:0]   carryVec;
  logic             ovfRaw;
  logic             msbSum;
  logic             lessBit;

  // Ripple: each bit's carry-out becomes the next bit's carry-in
  always_comb begin
    carryVec[0] = strobes.bNegate;
    for (int i = 0; i < WIDTH; i++) begin
      carryVec[i+1] = genVec[i] | (propVec[i] & carryVec[i]);
    end
  end

  always_comb begin
    ovfRaw  = carryVec[MSB] ^ carryVec[WIDTH];
    msbSum  = (propVec[MSB] & ~genVec[MSB]) ^ carryVec[MSB];
    lessBit = msbSum ^ ovfRaw;
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic lessIn;
    if (i == 0) begin : g_lsb
      assign lessIn = lessBit;
    end else begin : g_upper
      assign lessIn = 1'b0;
    end
    alu32_slice i_slice (
      .aBit    (opA[i]),
      .bBit    (opB[i]),
      .aInvert (strobes.aInvert),
      .bNegate (strobes.bNegate),
      .carryIn (carryVec[i]),
      .lessIn  (lessIn),
      .sel     (strobes.sel),
      .resBit  (sliceRes[i]),
      .gen     (genVec[i]),
      .prop    (propVec[i])
    );
  end

  always_comb begin
    result       = strobes.valid ? sliceRes : '0;
    zeroFlag     = strobes.valid & ~(|sliceRes);
    overflowFlag = strobes.arith & ovfRaw;
    carryOut     = strobes.arith & carryVec[WIDTH];
  end

endmodule

// File: rtl/alu32.sv
module alu32
  import alu32_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic [3:0]       ctrlWord,
  output logic [WIDTH-1:0] result,
  output logic             zeroFlag,
  output logic             overflowFlag,
  output logic             carryOut
);

  strobes_t strobes;

  alu32_control i_control (
    .ctrlWord (ctrlWord),
    .strobes  (strobes)
  );

  alu32_datapath #(.WIDTH(WIDTH)) i_datapath (
    .opA          (opA),
    .opB          (opB),
    .strobes      (strobes),
    .result       (result),
    .zeroFlag     (zeroFlag),
    .overflowFlag (overflowFlag),
    .carryOut     (carryOut)
  );

endmodule

// File: rtl/alu32_checker.sv
module alu32_checker #(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [3:0]       ctrlWord,
  input logic [WIDTH-1:0] result,
  input logic             zeroFlag,
  input logic             overflowFlag,
  input logic             carryOut
);

  logic listed;
  logic logicLike;

  always_comb begin
    listed = (ctrlWord == 4'b0000) || (ctrlWord == 4'b0001) || (ctrlWord == 4'b0010) ||
             (ctrlWord == 4'b0110) || (ctrlWord == 4'b0111) || (ctrlWord == 4'b1100);
    logicLike = (ctrlWord == 4'b0000) || (ctrlWord == 4'b0001) ||
                (ctrlWord == 4'b0111) || (ctrlWord == 4'b1100);
  end

  always_comb begin
    // R10
    unlisted_quiet_chk: assert (listed || (result == '0 && !zeroFlag && !overflowFlag && !carryOut))
      else $error("unlisted code produced output");
    // R9
    logic_flags_chk: assert (!logicLike || (!overflowFlag && !carryOut))
      else $error("flags raised on non-arithmetic code");
    // R5
    slt_value_chk: assert (ctrlWord != 4'b0111 ||
                           result == {{(WIDTH-1){1'b0}}, ($signed(opA) < $signed(opB))})
      else $error("set-on-less-than mismatch");
    // R6
    nor_value_chk: assert (ctrlWord != 4'b1100 || result == ~(opA | opB))
      else $error("NOR mismatch");
    // R7
    zero_flag_chk: assert (!listed || (zeroFlag == (result == '0)))
      else $error("zero flag inconsistent with result");
  end

endmodule

bind alu32 alu32_checker #(.WIDTH(WIDTH)) i_checker (
  .opA          (opA),
  .opB          (opB),
  .ctrlWord     (ctrlWord),
  .result       (result),
  .zeroFlag     (zeroFlag),
  .overflowFlag (overflowFlag),
  .carryOut     (carryOut)
);

// File: tb/test_alu32.sv
module test_alu32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  ctrlWord = '0;
  logic [31:0] result;
  logic        zeroFlag;
  logic        overflowFlag;
  logic        carryOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #2 clk = ~clk;

  alu32 i_alu32 (
    .opA          (opA),
    .opB          (opB),
    .ctrlWord     (ctrlWord),
    .result       (result),
    .zeroFlag     (zeroFlag),
    .overflowFlag (overflowFlag),
    .carryOut     (carryOut)
  );

  localparam logic [63:0] PAIRS [12] = '{
    64'h00000000_00000000, 64'h00000001_00000001, 64'hFFFFFFFF_00000001,
    64'h80000000_FFFFFFFF, 64'h7FFFFFFF_00000001, 64'h80000000_00000001,
    64'h7FFFFFFF_80000000, 64'h80000000_7FFFFFFF, 64'h12345678_12345678,
    64'h0F0F0F0F_F0F0F0F0, 64'h00000005_FFFFFFFB, 64'hA5A5A5A5_3C3C3C3C
  };
  localparam logic [3:0] CODES [6] = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};

  function automatic bit isListed(input logic [3:0] c);
    return c == 4'b0000 || c == 4'b0001 || c == 4'b0010 || c == 4'b0110 ||
           c == 4'b0111 || c == 4'b1100;
  endfunction

  function automatic string opTag(input logic [3:0] c);
    case (c)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R10";
    endcase
  endfunction

  // Behavioural reference: {carry, overflow, zero, result}
  function automatic logic [34:0] refAlu(input logic [31:0] a, input logic [31:0] b,
                                         input logic [3:0] c);
    logic [32:0] wide;
    logic [31:0] r;
    logic o;
    logic co;
    r = '0; o = 1'b0; co = 1'b0;
    case (c)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: begin
        wide = {1'b0, a} + {1'b0, b};
        r = wide[31:0]; co = wide[32];
        o = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'b0110: begin
        wide = {1'b0, a} + {1'b0, ~b} + 33'd1;
        r = wide[31:0]; co = wide[32];
        o = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'b0111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'b1100: r = ~(a | b);
      default: r = '0;
    endcase
    return {co, o, isListed(c) && (r == '0), r};
  endfunction

  task automatic checkBit(input string tag, input string what, input logic act, input logic exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0b expected %0b (a=%h b=%h code=%b)",
               tag, what, act, exp, opA, opB, ctrlWord);
    end
  endtask

  task automatic applyAndCheck(input logic [31:0] a, input logic [31:0] b, input logic [3:0] c);
    logic [34:0] exp;
    string flagTag;
    @(negedge clk);
    opA = a; opB = b; ctrlWord = c;
    #1;
    exp = refAlu(a, b, c);
    flagTag = isListed(c) ? ((c == 4'b0010 || c == 4'b0110) ? "R8" : "R9") : "R10";
    checkCount++;
    if (result !== exp[31:0]) begin
      failCount++;
      $display("FAIL %s result: actual %h expected %h (a=%h b=%h code=%b)",
               opTag(c), result, exp[31:0], a, b, c);
    end
    checkBit(isListed(c) ? "R7" : "R10", "zero", zeroFlag, exp[32]);
    checkBit(flagTag, "overflow", overflowFlag, exp[33]);
    checkBit((c == 4'b0010 || c == 4'b0110) ? opTag(c) : flagTag, "carry", carryOut, exp[34]);
  endtask

  task automatic checkLiteral(input string tag, input logic [31:0] a, input logic [31:0] b,
                              input logic [3:0] c, input logic [31:0] expR, input logic expZ,
                              input logic expO, input logic expC);
    @(negedge clk);
    opA = a; opB = b; ctrlWord = c;
    #1;
    checkCount++;
    if (result !== expR) begin
      failCount++;
      $display("FAIL %s result: actual %h expected %h", tag, result, expR);
    end
    checkBit(tag, "zero", zeroFlag, expZ);
    checkBit(tag, "overflow", overflowFlag, expO);
    checkBit(tag, "carry", carryOut, expC);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checkCount++;
    failCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // Reset state: all-zero inputs select AND on zeros (R1, R7)
    checkLiteral("R1", 32'h0, 32'h0, 4'b0000, 32'h0, 1'b1, 1'b0, 1'b0);

    // Vector table walk over every listed code
    for (int p = 0; p < 12; p++) begin
      for (int k = 0; k < 6; k++) begin
        applyAndCheck(PAIRS[p][63:32], PAIRS[p][31:0], CODES[k]);
      end
    end

    // R10: every unlisted code on a busy operand pair
    for (int c = 0; c < 16; c++) begin
      if (!isListed(4'(c))) applyAndCheck(32'hFFFFFFFF, 32'h00000001, 4'(c));
    end

    // Directed corners
    checkLiteral("R5", 32'h80000000, 32'h7FFFFFFF, 4'b0111, 32'd1, 1'b0, 1'b0, 1'b0);
    checkLiteral("R5", 32'h7FFFFFFF, 32'h80000000, 4'b0111, 32'd0, 1'b1, 1'b0, 1'b0);
    checkLiteral("R8", 32'h7FFFFFFF, 32'h00000001, 4'b0010, 32'h80000000, 1'b0, 1'b1, 1'b0);
    checkLiteral("R8", 32'h80000000, 32'h00000001, 4'b0110, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1);
    checkLiteral("R3", 32'hFFFFFFFF, 32'h00000001, 4'b0010, 32'h0, 1'b1, 1'b0, 1'b1);
    checkLiteral("R4", 32'h12345678, 32'h12345678, 4'b0110, 32'h0, 1'b1, 1'b0, 1'b1);
    checkLiteral("R4", 32'h00000000, 32'h00000001, 4'b0110, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);
    checkLiteral("R6", 32'h00000000, 32'h00000000, 4'b1100, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);
    checkLiteral("R10", 32'h00000000, 32'h00000000, 4'b1111, 32'h0, 1'b0, 1'b0, 1'b0);
    checkLiteral("R2", 32'h0000FFFF, 32'hFFFF0000, 4'b0001, 32'hFFFFFFFF, 1'b0, 1'b0, 1'b0);
    finish();
  end

endmodule